// File: doc/BRIEF.md
# Shared Functional Unit Issue Tracker

This block sits at the issue stage of a processor core in which several thread contexts share one pool of execution units. Each cycle it takes up to a fixed number of issue requests. Any request may come from any thread context. Each request names a thread, a destination register tag and a unit class. The block places every request it can on a free unit of the matching class and turns away the rest. For each cycle it reports which slots were accepted, which were rejected, and how many were rejected.

There are four unit classes, each with its own unit count and fixed latency: integer ALU, integer multiply/divide, memory port (assumed to always hit) and floating-point ALU. Every unit is fully pipelined. An accepted operation travels down the pipeline of its unit. Exactly the class latency later it appears on that unit's completion lane, carrying its thread ID and destination tag. The block does not handle operand values, register files or hazards.

The allocator is combinational, so it has no control states. Each unit is a plain shift pipeline with two conditions: reset, where every stage is cleared, and run, where every stage shifts by one per clock.

Top module: `fu_issue_tracker`

## Requirements
- R1: Class code 0 (integer ALU) has 4 units on completion lanes 0 to 3, and each has a latency of 1 cycle.
- R2: Class code 1 (multiply/divide) has 1 unit on completion lane 4, with a latency of 3 cycles.
- R3: Class code 2 (memory port) has 3 units on completion lanes 5 to 7, and each has a latency of 2 cycles.
- R4: Class code 3 (floating-point ALU) has 2 units on completion lanes 8 and 9, and each has a latency of 5 cycles.
- R5: Within a cycle, a lower slot index is served first. A valid request is rejected exactly when all units of its class have already been given to lower slots in that cycle. Accept and reject are combinational in the same cycle as the request.
- R6: The k-th accepted request of a class in a cycle, counted in slot order from k = 0, goes to unit k of that class. Its completion lane carries the request's thread ID and destination tag.
- R7: Each unit accepts a new operation every cycle, whatever it already has in flight.
- R8: A slot whose valid bit is low is neither accepted nor rejected. The reject count equals the number of rejected slots in the same cycle.
- R9: Synchronous reset clears every operation in flight. From the cycle after reset until new requests are accepted, no completion lane is valid.
- R10: Requests from different thread contexts and of different classes are all placed in the same cycle when units are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 4 | Per-slot request valid |
| req_class | input | 8 | Per-slot 2-bit class code; slot s uses bits [2s+1:2s] |
| req_tid | input | 8 | Per-slot 2-bit thread ID |
| req_dst | input | 20 | Per-slot 5-bit destination tag |
| req_accept | output | 4 | Per-slot accept flag |
| req_reject | output | 4 | Per-slot reject flag |
| reject_count | output | 3 | Number of slots rejected this cycle |
| cmp_valid | output | 10 | Per-lane completion valid |
| cmp_tid | output | 20 | Per-lane 2-bit thread ID |
| cmp_dst | output | 50 | Per-lane 5-bit destination tag |

## Verification
The bench builds the block with its default parameters: four request slots, and unit counts of 4, 1, 3 and 2 with latencies of 1, 3, 2 and 5. Because there are four slots, a single cycle can oversubscribe every class except the ALU. Such cycles expose rejection in slot order, the reject count, and the placement of the k-th request on lane base+k. The five-cycle floating-point latency keeps operations in flight long enough for back-to-back issue and a reset in mid-flight to be checked lane by lane.

// File: rtl/fu_pkg.sv
package fu_pkg;
    typedef enum logic [1:0] {
        FU_ALU = 2'd0,
        FU_MUL = 2'd1,
        FU_MEM = 2'd2,
        FU_FPU = 2'd3
    } fu_class_e;

    localparam int FU_NCLASS = 4;
endpackage

// File: rtl/fu_class_alloc.sv
module fu_class_alloc #(
    parameter int N_SLOTS = 4,
    parameter int COUNT   = 4,
    parameter int TID_W   = 2,
    parameter int DST_W   = 5,
    parameter fu_pkg::fu_class_e CLS = fu_pkg::FU_ALU
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_SLOTS-1:0]       req_valid,
    input  logic [N_SLOTS*2-1:0]     req_class,
    input  logic [N_SLOTS*TID_W-1:0] req_tid,
    input  logic [N_SLOTS*DST_W-1:0] req_dst,
    output logic [N_SLOTS-1:0]       grant,
    output logic [N_SLOTS-1:0]       deny,
    output logic [COUNT-1:0]         unit_valid,
    output logic [COUNT*TID_W-1:0]   unit_tid,
    output logic [COUNT*DST_W-1:0]   unit_dst
);
    int taken;

    // slot-order placement: k-th match of this class lands on unit k
    always_comb begin
        taken      = 0;
        grant      = '0;
        deny       = '0;
        unit_valid = '0;
        unit_tid   = '0;
        unit_dst   = '0;
        for (int s = 0; s < N_SLOTS; s++) begin
            if (req_valid[s] && (fu_pkg::fu_class_e'(req_class[s*2 +: 2]) == CLS)) begin
                if (taken < COUNT) begin
                    grant[s] = 1'b1;
                    for (int u = 0; u < COUNT; u++) begin
                        if (u == taken) begin
                            unit_valid[u]               = 1'b1;
                            unit_tid[u*TID_W +: TID_W]  = req_tid[s*TID_W +: TID_W];
                            unit_dst[u*DST_W +: DST_W]  = req_dst[s*DST_W +: DST_W];
                        end
                    end
                    taken = taken + 1;
                end else begin
                    deny[s] = 1'b1;
                end
            end
        end
    end

    assert_no_oversubscribe_R5: assert property (@(posedge clk) disable iff (rst)
        ($countones(unit_valid) == $countones(grant)) && ($countones(grant) <= COUNT));

    assert_grant_deny_disjoint_R5: assert property (@(posedge clk) disable iff (rst)
        ((grant & deny) == '0) && (((grant | deny) & ~req_valid) == '0));
endmodule

// File: rtl/fu_pipe.sv
module fu_pipe #(
    parameter int LAT   = 1,
    parameter int TID_W = 2,
    parameter int DST_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [TID_W-1:0] in_tid,
    input  logic [DST_W-1:0] in_dst,
    output logic             out_valid,
    output logic [TID_W-1:0] out_tid,
    output logic [DST_W-1:0] out_dst
);
    logic [LAT-1:0]   stage_v;
    logic [TID_W-1:0] stage_t [LAT];
    logic [DST_W-1:0] stage_d [LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_v <= '0;
            for (int i = 0; i < LAT; i++) begin
                stage_t[i] <= '0;
                stage_d[i] <= '0;
            end
        end else begin
            stage_v[0] <= in_valid;
            stage_t[0] <= in_tid;
            stage_d[0] <= in_dst;
            for (int i = 1; i < LAT; i++) begin
                stage_v[i] <= stage_v[i-1];
                stage_t[i] <= stage_t[i-1];
                stage_d[i] <= stage_d[i-1];
            end
        end
    end

    assign out_valid = stage_v[LAT-1];
    assign out_tid   = stage_t[LAT-1];
    assign out_dst   = stage_d[LAT-1];

    assert_reset_flush_R9: assert property (@(posedge clk) rst |=> !out_valid);

    generate
        if (LAT == 1) begin : g_single
            assert_one_cycle_latency_R1: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> (out_valid == $past(in_valid)));
        end
    endgenerate
endmodule

// File: rtl/fu_issue_tracker.sv
module fu_issue_tracker #(
    parameter int N_SLOTS = 4,
    parameter int TID_W   = 2,
    parameter int DST_W   = 5,
    parameter int N_ALU   = 4,
    parameter int N_MUL   = 1,
    parameter int N_MEM   = 3,
    parameter int N_FPU   = 2,
    parameter int LAT_ALU = 1,
    parameter int LAT_MUL = 3,
    parameter int LAT_MEM = 2,
    parameter int LAT_FPU = 5,
    localparam int NU     = N_ALU + N_MUL + N_MEM + N_FPU,
    localparam int RC_W   = $clog2(N_SLOTS + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_SLOTS-1:0]       req_valid,
    input  logic [N_SLOTS*2-1:0]     req_class,
    input  logic [N_SLOTS*TID_W-1:0] req_tid,
    input  logic [N_SLOTS*DST_W-1:0] req_dst,
    output logic [N_SLOTS-1:0]       req_accept,
    output logic [N_SLOTS-1:0]       req_reject,
    output logic [RC_W-1:0]          reject_count,
    output logic [NU-1:0]            cmp_valid,
    output logic [NU*TID_W-1:0]      cmp_tid,
    output logic [NU*DST_W-1:0]      cmp_dst
);
    import fu_pkg::*;

    localparam int CNT  [FU_NCLASS] = '{N_ALU, N_MUL, N_MEM, N_FPU};
    localparam int BASE [FU_NCLASS] = '{0, N_ALU, N_ALU + N_MUL, N_ALU + N_MUL + N_MEM};

    logic [N_SLOTS-1:0]  grant_c [FU_NCLASS];
    logic [N_SLOTS-1:0]  deny_c  [FU_NCLASS];
    logic [NU-1:0]       lane_v;
    logic [NU*TID_W-1:0] lane_t;
    logic [NU*DST_W-1:0] lane_d;

    generate
        for (genvar c = 0; c < FU_NCLASS; c++) begin : g_class
            fu_class_alloc #(
                .N_SLOTS (N_SLOTS),
                .COUNT   (CNT[c]),
                .TID_W   (TID_W),
                .DST_W   (DST_W),
                .CLS     (fu_class_e'(c))
            ) i_alloc (
                .clk        (clk),
                .rst        (rst),
                .req_valid  (req_valid),
                .req_class  (req_class),
                .req_tid    (req_tid),
                .req_dst    (req_dst),
                .grant      (grant_c[c]),
                .deny       (deny_c[c]),
                .unit_valid (lane_v[BASE[c] +: CNT[c]]),
                .unit_tid   (lane_t[BASE[c]*TID_W +: CNT[c]*TID_W]),
                .unit_dst   (lane_d[BASE[c]*DST_W +: CNT[c]*DST_W])
            );
        end

        for (genvar u = 0; u < NU; u++) begin : g_unit
            localparam int L = (u < BASE[1]) ? LAT_ALU :
                               (u < BASE[2]) ? LAT_MUL :
                               (u < BASE[3]) ? LAT_MEM : LAT_FPU;
            fu_pipe #(
                .LAT   (L),
                .TID_W (TID_W),
                .DST_W (DST_W)
            ) i_pipe (
                .clk       (clk),
                .rst       (rst),
                .in_valid  (lane_v[u]),
                .in_tid    (lane_t[u*TID_W +: TID_W]),
                .in_dst    (lane_d[u*DST_W +: DST_W]),
                .out_valid (cmp_valid[u]),
                .out_tid   (cmp_tid[u*TID_W +: TID_W]),
                .out_dst   (cmp_dst[u*DST_W +: DST_W])
            );
        end
    endgenerate

    always_comb begin
        req_accept = '0;
        req_reject = '0;
        for (int c = 0; c < FU_NCLASS; c++) begin
            req_accept = req_accept | grant_c[c];
            req_reject = req_reject | deny_c[c];
        end
    end

    always_comb begin
        reject_count = '0;
        for (int s = 0; s < N_SLOTS; s++) begin
            reject_count = reject_count + RC_W'(req_reject[s]);
        end
    end

    assert_every_valid_answered_R8: assert property (@(posedge clk) disable iff (rst)
        ((req_accept & req_reject) == '0) && ((req_accept | req_reject) == req_valid));

    assert_reject_count_matches_R8: assert property (@(posedge clk) disable iff (rst)
        $countones(req_reject) == int'(reject_count));

    assert_no_completion_after_reset_R9: assert property (@(posedge clk)
        rst |=> (cmp_valid == '0));
endmodule

// File: tb/test_fu_issue_tracker.sv
module test_fu_issue_tracker;
    localparam int NS = 4;
    localparam int NU = 10;
    localparam int CNT  [4] = '{4, 1, 3, 2};
    localparam int BASE [4] = '{0, 4, 5, 8};
    localparam int LAT  [4] = '{1, 3, 2, 5};
    localparam int NV = 12;
    // {valid[3:0], class[7:0] (slot3..slot0), expected accept[3:0]}
    localparam logic [15:0] VEC [NV] = '{
        {4'b1111, 8'b00000000, 4'b1111},  // four ALU
        {4'b1111, 8'b01010101, 4'b0001},  // four MUL, one unit
        {4'b1111, 8'b10101010, 4'b0111},  // four MEM, three units
        {4'b1111, 8'b11111111, 4'b0011},  // four FPU, two units
        {4'b1111, 8'b11100100, 4'b1111},  // one of each class, R10
        {4'b1111, 8'b01000100, 4'b0111},  // MUL in slots 1 and 3
        {4'b0101, 8'b11111111, 4'b0101},  // sparse FPU
        {4'b0000, 8'b00000000, 4'b0000},  // idle
        {4'b0001, 8'b00000001, 4'b0001},  // MUL back to back, R7
        {4'b0001, 8'b00000001, 4'b0001},
        {4'b1100, 8'b11110000, 4'b1100},  // FPU in high slots
        {4'b0011, 8'b00001111, 4'b0011}   // FPU in low slots, R7
    };

    logic           clk = 1'b0;
    logic           rst;
    logic [NS-1:0]  req_valid;
    logic [NS*2-1:0] req_class;
    logic [NS*2-1:0] req_tid;
    logic [NS*5-1:0] req_dst;
    logic [NS-1:0]  req_accept;
    logic [NS-1:0]  req_reject;
    logic [2:0]     reject_count;
    logic [NU-1:0]  cmp_valid;
    logic [NU*2-1:0] cmp_tid;
    logic [NU*5-1:0] cmp_dst;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [NU-1:0] exp_v [8];
    logic [1:0]    exp_t [8][NU];
    logic [4:0]    exp_d [8][NU];

    always #2 clk = ~clk;

    fu_issue_tracker i_fu_issue_tracker (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_class    (req_class),
        .req_tid      (req_tid),
        .req_dst      (req_dst),
        .req_accept   (req_accept),
        .req_reject   (req_reject),
        .reject_count (reject_count),
        .cmp_valid    (cmp_valid),
        .cmp_tid      (cmp_tid),
        .cmp_dst      (cmp_dst)
    );

    function automatic string lane_req(int l);
        if (l < 4) return "R1";
        if (l < 5) return "R2";
        if (l < 8) return "R3";
        return "R4";
    endfunction

    task automatic clear_exp();
        for (int i = 0; i < 8; i++) begin
            exp_v[i] = '0;
            for (int l = 0; l < NU; l++) begin
                exp_t[i][l] = '0;
                exp_d[i][l] = '0;
            end
        end
    endtask

    task automatic check_cmp();
        int i;
        i = cyc % 8;
        for (int l = 0; l < NU; l++) begin
            checks++;
            if (cmp_valid[l] !== exp_v[i][l]) begin
                errors++;
                $display("FAIL %s/R9 cycle %0d lane %0d valid: actual %b expected %b",
                         lane_req(l), cyc, l, cmp_valid[l], exp_v[i][l]);
            end else if (exp_v[i][l] && ((cmp_tid[l*2 +: 2] !== exp_t[i][l]) ||
                                         (cmp_dst[l*5 +: 5] !== exp_d[i][l]))) begin
                errors++;
                $display("FAIL R6 cycle %0d lane %0d tag: actual %0d/%0d expected %0d/%0d",
                         cyc, l, cmp_tid[l*2 +: 2], cmp_dst[l*5 +: 5], exp_t[i][l], exp_d[i][l]);
            end
        end
        exp_v[i] = '0;
    endtask

    task automatic step(input logic [3:0] v, input logic [7:0] cls, input int vi,
                        input bit use_exp, input logic [3:0] eacc);
        int k [4];
        int c, lane, d;
        logic [3:0] erej;
        @(negedge clk);
        check_cmp();
        req_valid = v;
        req_class = cls;
        for (int q = 0; q < 4; q++) k[q] = 0;
        for (int s = 0; s < NS; s++) begin
            req_tid[s*2 +: 2] = 2'((s + vi) % 4);
            req_dst[s*5 +: 5] = 5'((vi * 4 + s) % 32);
            if (v[s]) begin
                c = int'(cls[s*2 +: 2]);
                if (k[c] < CNT[c]) begin
                    lane = BASE[c] + k[c];
                    d = (cyc + LAT[c]) % 8;
                    exp_v[d][lane] = 1'b1;
                    exp_t[d][lane] = 2'((s + vi) % 4);
                    exp_d[d][lane] = 5'((vi * 4 + s) % 32);
                    k[c]++;
                end
            end
        end
        #1;
        if (use_exp) begin
            erej = v & ~eacc;
            checks++;
            if (req_accept !== eacc) begin
                errors++;
                $display("FAIL R5 vector %0d accept: actual %b expected %b", vi, req_accept, eacc);
            end
            checks++;
            if (req_reject !== erej) begin
                errors++;
                $display("FAIL R8 vector %0d reject: actual %b expected %b", vi, req_reject, erej);
            end
            checks++;
            if (int'(reject_count) != $countones(erej)) begin
                errors++;
                $display("FAIL R8 vector %0d count: actual %0d expected %0d",
                         vi, reject_count, $countones(erej));
            end
        end
        @(posedge clk);
        cyc++;
    endtask

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        req_valid = '0;
        req_class = '0;
        req_tid = '0;
        req_dst = '0;
        clear_exp();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // reset state, R9
        checks++;
        if (cmp_valid !== '0 || reject_count !== 3'd0 || req_accept !== '0) begin
            errors++;
            $display("FAIL R9 reset state: actual %b/%0d expected 0/0", cmp_valid, reject_count);
        end

        // table walk: R1..R8, R10
        for (int vi = 0; vi < NV; vi++) begin
            step(VEC[vi][15:12], VEC[vi][11:4], vi, 1'b1, VEC[vi][3:0]);
        end
        // drain and observe remaining completions
        for (int n = 0; n < 7; n++) step(4'b0000, 8'h00, 20 + n, 1'b1, 4'b0000);

        // reset in mid-flight, R9: MUL in slot0, FPU in slot1
        step(4'b0011, 8'b00001101, 30, 1'b1, 4'b0011);
        @(negedge clk);
        check_cmp();
        rst = 1'b1;
        req_valid = '0;
        clear_exp();
        @(posedge clk);
        cyc++;
        #1 rst = 1'b0;
        for (int n = 0; n < 7; n++) step(4'b0000, 8'h00, 31 + n, 1'b1, 4'b0000);

        // issue after reset resumes normally, R6
        step(4'b1111, 8'b11100100, 40, 1'b1, 4'b1111);
        for (int n = 0; n < 7; n++) step(4'b0000, 8'h00, 41 + n, 1'b1, 4'b0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule